// File: doc/BRIEF.md
# Multi-channel output port word scheduler

This block shares one output port among several channels that produce samples at a common rate. When a sample arrives, it latches every participating channel's I, Q and gain values together with the selected word format. It then plays out a frame: one overhead cycle, marked by a start strobe, followed by the data words of each latched channel. Each data word carries the channel index and a word-type tag, so a downstream receiver can demultiplex the stream without knowing the frame layout in advance.

Four word formats trade port cycles against content. The frame length is the number of latched channels times the words per channel, plus one overhead cycle. If the next sample arrives while a frame is still playing out, the frame would not fit in the sample period. That sample is dropped and a one-cycle overrun flag is raised.

Top module: `osched_port_sched`

## Requirements
- R1: After reset, `port_valid`, `frame_start` and `overrun` are low, and `port_data`, `port_ch` and `port_wtype` are zero.
- R2: A sample arrives on a cycle where `ch_valid & ch_en` is nonzero; a valid bit on a disabled channel alone starts nothing. An arrival accepted while idle gives `frame_start` high, with `port_valid` low, in the next cycle (the overhead cycle). The data words follow in the cycles directly after it.
- R3: A frame lasts N*W+1 cycles. N is the number of latched channels. W is 3, 2, 2 or 1 for `fmt_sel` codes 0, 1, 2 and 3. For example, two channels in format 0 take 7 cycles.
- R4: Latched channels leave in ascending index order, and unlatched channels are skipped. All words of one channel are consecutive, and `port_ch` gives the index during each data cycle.
- R5: In format 0, each channel sends I (word-type 0), then Q (word-type 1), then gain (word-type 3).
- R6: In format 1, each channel sends a packed IQ word (word-type 2), then gain. The packed word has the upper half of I in its upper half and the upper half of Q in its lower half.
- R7: In format 2, each channel sends I, then Q, with no gain word.
- R8: In format 3, each channel sends only the packed IQ word.
- R9: Data, channel set and format are captured at the arrival. Input changes during a frame do not alter it.
- R10: An arrival during a frame, in any cycle but its final data cycle, is dropped. `overrun` is high for one cycle in the next cycle, and the running frame continues unchanged.
- R11: An arrival in the final data cycle of a frame is accepted, and its overhead cycle follows immediately.
- R12: Whenever `port_valid` is low, `port_ch`, `port_wtype` and `port_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Channel enable mask |
| ch_valid | input | NUM_CH | Per-channel sample valid |
| ch_i | input | NUM_CH*DATA_W | I samples, channel k at bits [k*DATA_W +: DATA_W] |
| ch_q | input | NUM_CH*DATA_W | Q samples, same packing |
| ch_gain | input | NUM_CH*DATA_W | Gain words, same packing |
| fmt_sel | input | 2 | Word format code 0..3 |
| port_data | output | DATA_W | Port word |
| port_valid | output | 1 | Data cycle |
| port_ch | output | max(1,clog2(NUM_CH)) | Channel index of the word |
| port_wtype | output | 2 | Word type: 0 I, 1 Q, 2 packed IQ, 3 gain |
| frame_start | output | 1 | Overhead cycle of a frame |
| overrun | output | 1 | Previous cycle's sample was dropped |

## Verification
An arrival sampled at a clock edge yields `frame_start` in the cycle right after that edge. The k-th data word of the frame follows k cycles later, and `overrun` for a dropped sample appears in the cycle after the edge that sampled it. The bench's reference model keeps a queue of expected per-cycle outputs, appended at each accepted arrival and popped once per edge. The outputs are compared against the head of that queue at the falling edge, so every result is checked in exactly the cycle it is due. Directed runs also count frame lengths, overrun pulses and back-to-back frame starts.

// File: rtl/osched_pkg.sv
package osched_pkg;

   typedef enum logic [1:0] {
      FMT_IQG  = 2'd0,
      FMT_PIQG = 2'd1,
      FMT_IQ   = 2'd2,
      FMT_PK   = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      WT_I    = 2'd0,
      WT_Q    = 2'd1,
      WT_IQ   = 2'd2,
      WT_GAIN = 2'd3
   } wtype_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OVH  = 2'd1,
      ST_DATA = 2'd2
   } st_e;

   // words each channel occupies on the port (R3)
   function automatic logic [1:0] words_per_ch(fmt_e f);
      case (f)
         FMT_IQG:  return 2'd3;
         FMT_PIQG: return 2'd2;
         FMT_IQ:   return 2'd2;
         default:  return 2'd1;
      endcase
   endfunction

   // type of word number idx within one channel (R5..R8)
   function automatic wtype_e word_type(fmt_e f, logic [1:0] idx);
      case (f)
         FMT_IQG:  return (idx == 2'd0) ? WT_I  : ((idx == 2'd1) ? WT_Q : WT_GAIN);
         FMT_PIQG: return (idx == 2'd0) ? WT_IQ : WT_GAIN;
         FMT_IQ:   return (idx == 2'd0) ? WT_I  : WT_Q;
         default:  return WT_IQ;
      endcase
   endfunction

endpackage

// File: rtl/osched_next_ch.sv
module osched_next_ch #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int FW    = CH_W + 1
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [FW-1:0]     floor_idx,
   output logic              found,
   output logic [CH_W-1:0]   idx
);

   logic [NUM_CH-1:0] elig;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_elig
         assign elig[g] = mask[g] && (FW'(g) >= floor_idx);
      end
   endgenerate

   // lowest eligible channel wins (R4 ascending order)
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         if (elig[k]) begin
            found = 1'b1;
            idx   = CH_W'(k);
         end
      end
   end

endmodule

// File: rtl/osched_word_mux.sv
module osched_word_mux
   import osched_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int HALF  = DATA_W / 2
) (
   input  logic [NUM_CH*DATA_W-1:0] i_bus,
   input  logic [NUM_CH*DATA_W-1:0] q_bus,
   input  logic [NUM_CH*DATA_W-1:0] g_bus,
   input  logic [CH_W-1:0]          sel_ch,
   input  wtype_e                   wt,
   output logic [DATA_W-1:0]        word
);

   logic [DATA_W-1:0] i_arr [NUM_CH];
   logic [DATA_W-1:0] q_arr [NUM_CH];
   logic [DATA_W-1:0] g_arr [NUM_CH];

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_split
         assign i_arr[g] = i_bus[g*DATA_W +: DATA_W];
         assign q_arr[g] = q_bus[g*DATA_W +: DATA_W];
         assign g_arr[g] = g_bus[g*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      case (wt)
         WT_I:    word = i_arr[sel_ch];
         WT_Q:    word = q_arr[sel_ch];
         WT_IQ:   word = {i_arr[sel_ch][DATA_W-1 -: HALF], q_arr[sel_ch][DATA_W-1 -: HALF]};
         default: word = g_arr[sel_ch];
      endcase
   end

endmodule

// File: rtl/osched_port_sched.sv
module osched_port_sched
   import osched_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int FW    = CH_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        ch_en,
   input  logic [NUM_CH-1:0]        ch_valid,
   input  logic [NUM_CH*DATA_W-1:0] ch_i,
   input  logic [NUM_CH*DATA_W-1:0] ch_q,
   input  logic [NUM_CH*DATA_W-1:0] ch_gain,
   input  logic [1:0]               fmt_sel,
   output logic [DATA_W-1:0]        port_data,
   output logic                     port_valid,
   output logic [CH_W-1:0]          port_ch,
   output logic [1:0]               port_wtype,
   output logic                     frame_start,
   output logic                     overrun
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_w
         $error("DATA_W must be even and at least 2");
      end
   endgenerate

   st_e                     st_q;
   fmt_e                    fmt_q;
   logic [NUM_CH-1:0]       mask_q;
   logic [CH_W-1:0]         cur_q;
   logic [1:0]              widx_q;
   logic [NUM_CH*DATA_W-1:0] lat_i, lat_q, lat_g;
   logic                    overrun_q;

   logic [NUM_CH-1:0] cap_mask;
   logic              arrive, can_accept, accept;
   logic [1:0]        wpc;
   logic              ch_last_word, frame_last;
   logic              nxt_found, first_found;
   logic [CH_W-1:0]   nxt_idx, first_idx;
   wtype_e            cur_wt;
   logic [DATA_W-1:0] mux_word;

   assign cap_mask = ch_valid & ch_en;
   assign arrive   = |cap_mask;

   osched_next_ch #(.NUM_CH(NUM_CH)) u_first (
      .mask      (mask_q),
      .floor_idx ('0),
      .found     (first_found),
      .idx       (first_idx)
   );

   osched_next_ch #(.NUM_CH(NUM_CH)) u_next (
      .mask      (mask_q),
      .floor_idx ({1'b0, cur_q} + FW'(1)),
      .found     (nxt_found),
      .idx       (nxt_idx)
   );

   assign wpc          = words_per_ch(fmt_q);
   assign ch_last_word = (widx_q == (wpc - 2'd1));
   assign frame_last   = (st_q == ST_DATA) && ch_last_word && !nxt_found;
   assign can_accept   = (st_q == ST_IDLE) || frame_last;
   assign accept       = arrive && can_accept;
   assign cur_wt       = word_type(fmt_q, widx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         fmt_q     <= FMT_IQG;
         mask_q    <= '0;
         cur_q     <= '0;
         widx_q    <= '0;
         lat_i     <= '0;
         lat_q     <= '0;
         lat_g     <= '0;
         overrun_q <= 1'b0;
      end else begin
         overrun_q <= arrive && !can_accept;
         if (accept) begin
            st_q   <= ST_OVH;
            fmt_q  <= fmt_e'(fmt_sel);
            mask_q <= cap_mask;
            lat_i  <= ch_i;
            lat_q  <= ch_q;
            lat_g  <= ch_gain;
            cur_q  <= '0;
            widx_q <= '0;
         end else begin
            case (st_q)
               ST_OVH: begin
                  st_q   <= first_found ? ST_DATA : ST_IDLE;
                  cur_q  <= first_idx;
                  widx_q <= '0;
               end
               ST_DATA: begin
                  if (!ch_last_word) begin
                     widx_q <= widx_q + 2'd1;
                  end else if (nxt_found) begin
                     cur_q  <= nxt_idx;
                     widx_q <= '0;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   osched_word_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mux (
      .i_bus  (lat_i),
      .q_bus  (lat_q),
      .g_bus  (lat_g),
      .sel_ch (cur_q),
      .wt     (cur_wt),
      .word   (mux_word)
   );

   assign frame_start = (st_q == ST_OVH);
   assign port_valid  = (st_q == ST_DATA);
   assign port_ch     = port_valid ? cur_q : '0;
   assign port_wtype  = port_valid ? cur_wt : 2'd0;
   assign port_data   = port_valid ? mux_word : '0;
   assign overrun     = overrun_q;

   // R2: the overhead cycle is followed directly by a data word
   a_r2_start_then_data: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (port_valid && !frame_start));

   // R4: channel index never decreases inside a run of data words
   a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (port_valid && $past(port_valid)) |-> (port_ch >= $past(port_ch)));

   // R4: within a channel no word follows gain and I never follows another word
   a_r4_word_order: assert property (@(posedge clk) disable iff (!rst_n)
      (port_valid && $past(port_valid) && port_ch == $past(port_ch))
         |-> (port_wtype != 2'd0 && $past(port_wtype) != 2'd3));

   // R10: a dropped sample is only ever reported while a frame is still sending
   a_r10_overrun_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> port_valid);

endmodule

// File: tb/osched_port_sched_test.sv
`timescale 1ns/1ps
module osched_port_sched_test;

   localparam int NUM_CH = 4;
   localparam int DATA_W = 16;
   localparam int CH_W   = 2;
   localparam int HALF   = DATA_W / 2;

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [NUM_CH-1:0]        ch_en = '0;
   logic [NUM_CH-1:0]        ch_valid = '0;
   logic [NUM_CH*DATA_W-1:0] ch_i = '0, ch_q = '0, ch_gain = '0;
   logic [1:0]               fmt_sel = '0;
   logic [DATA_W-1:0]        port_data;
   logic                     port_valid;
   logic [CH_W-1:0]          port_ch;
   logic [1:0]               port_wtype;
   logic                     frame_start;
   logic                     overrun;

   osched_port_sched #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_valid(ch_valid),
      .ch_i(ch_i), .ch_q(ch_q), .ch_gain(ch_gain), .fmt_sel(fmt_sel),
      .port_data(port_data), .port_valid(port_valid), .port_ch(port_ch),
      .port_wtype(port_wtype), .frame_start(frame_start), .overrun(overrun)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic check(string req, string what, int unsigned act, int unsigned exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   typedef struct packed {
      logic              fs;
      logic              pv;
      logic [CH_W-1:0]   ch;
      logic [1:0]        wt;
      logic [DATA_W-1:0] d;
      logic [1:0]        fm;
   } ent_t;

   ent_t q[$];
   ent_t exp_cur = '0;
   logic exp_ov  = 1'b0;

   function automatic logic [DATA_W-1:0] sl(logic [NUM_CH*DATA_W-1:0] b, int c);
      return b[c*DATA_W +: DATA_W];
   endfunction

   task automatic push_word(int c, logic [1:0] wt, logic [DATA_W-1:0] d, logic [1:0] f);
      ent_t e;
      e.fs = 1'b0; e.pv = 1'b1; e.ch = CH_W'(c); e.wt = wt; e.d = d; e.fm = f;
      q.push_back(e);
   endtask

   task automatic push_frame();
      ent_t e;
      logic [NUM_CH-1:0] m;
      logic [DATA_W-1:0] iw, qw, gw, pk;
      m = ch_valid & ch_en;
      e = '0; e.fs = 1'b1;
      q.push_back(e);
      for (int c = 0; c < NUM_CH; c++) begin
         if (m[c]) begin
            iw = sl(ch_i, c); qw = sl(ch_q, c); gw = sl(ch_gain, c);
            pk = {iw[DATA_W-1 -: HALF], qw[DATA_W-1 -: HALF]};
            case (fmt_sel)
               2'd0: begin push_word(c, 2'd0, iw, 2'd0); push_word(c, 2'd1, qw, 2'd0); push_word(c, 2'd3, gw, 2'd0); end
               2'd1: begin push_word(c, 2'd2, pk, 2'd1); push_word(c, 2'd3, gw, 2'd1); end
               2'd2: begin push_word(c, 2'd0, iw, 2'd2); push_word(c, 2'd1, qw, 2'd2); end
               default: push_word(c, 2'd2, pk, 2'd3);
            endcase
         end
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         exp_cur = '0;
         exp_ov  = 1'b0;
      end else begin
         logic arr;
         arr = |(ch_valid & ch_en);
         exp_ov = 1'b0;
         if (arr) begin
            if (q.size() == 0) push_frame();   // R11: accepted in final data cycle too
            else exp_ov = 1'b1;                // R10: dropped
         end
         exp_cur = (q.size() != 0) ? q.pop_front() : '0;
      end
   end

   function automatic string fmt_tag(logic [1:0] f);
      case (f)
         2'd0: return "R5";
         2'd1: return "R6";
         2'd2: return "R7";
         default: return "R8";
      endcase
   endfunction

   int fs_cnt = 0;
   int ov_cnt = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (frame_start) fs_cnt++;
         if (overrun) ov_cnt++;
         check("R2", "frame_start", frame_start, exp_cur.fs);
         check("R3", "port_valid", port_valid, exp_cur.pv);
         check("R10", "overrun", overrun, exp_ov);
         if (exp_cur.pv) begin
            check("R4", "port_ch", port_ch, exp_cur.ch);
            check(fmt_tag(exp_cur.fm), "port_wtype", port_wtype, exp_cur.wt);
            check({fmt_tag(exp_cur.fm), " R9"}, "port_data", port_data, exp_cur.d);
         end else begin
            check("R12", "idle tags", {port_ch, port_wtype, port_data}, 0);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic scramble();
      for (int c = 0; c < NUM_CH; c++) begin
         ch_i[c*DATA_W +: DATA_W]    = DATA_W'($urandom);
         ch_q[c*DATA_W +: DATA_W]    = DATA_W'($urandom);
         ch_gain[c*DATA_W +: DATA_W] = DATA_W'($urandom);
      end
   endtask

   // drive one arrival cycle, then valid low with fresh data (R9)
   task automatic pulse(logic [NUM_CH-1:0] m, logic [1:0] f);
      scramble();
      ch_valid = m;
      fmt_sel  = f;
      @(negedge clk);
      ch_valid = '0;
      fmt_sel  = ~f;
      scramble();
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         scramble();
         @(negedge clk);
      end
   endtask

   task automatic run_len(logic [NUM_CH-1:0] m, logic [1:0] f, int exp_len);
      int cnt;
      ch_en = '1;
      pulse(m, f);
      cnt = 0;
      while (frame_start || port_valid) begin
         cnt++;
         scramble();
         @(negedge clk);
      end
      check("R3", "frame length", cnt, exp_len);
   endtask

   initial begin
      int fs0, ov0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", "reset outputs", {port_valid, frame_start, overrun}, 0);
      check("R1", "reset data", {port_ch, port_wtype, port_data}, 0);
      rst_n = 1'b1;
      idle(2);

      // R3 frame lengths for each format
      run_len(4'b0101, 2'd0, 7);
      run_len(4'b1111, 2'd1, 9);
      run_len(4'b1000, 2'd2, 3);
      run_len(4'b0111, 2'd3, 4);
      idle(2);

      // R2: valid on disabled channels only starts nothing
      fs0 = fs_cnt;
      ch_en = 4'b0001;
      pulse(4'b1110, 2'd0);
      idle(4);
      check("R2", "disabled channels frames", fs_cnt - fs0, 0);

      // R10: arrival mid-frame is dropped with a single overrun pulse
      ch_en = '1;
      ov0 = ov_cnt;
      pulse(4'b1111, 2'd0);
      idle(3);
      pulse(4'b0011, 2'd3);
      idle(16);
      check("R10", "overrun pulses", ov_cnt - ov0, 1);

      // R11: arrivals in the last data cycle give back-to-back frames
      fs0 = fs_cnt;
      ov0 = ov_cnt;
      pulse(4'b0011, 2'd2);
      idle(4);
      pulse(4'b0011, 2'd2);
      idle(4);
      pulse(4'b0011, 2'd2);
      idle(8);
      check("R11", "back-to-back frames", fs_cnt - fs0, 3);
      check("R11", "no overrun", ov_cnt - ov0, 0);

      // mixed random traffic
      for (int k = 0; k < 3000; k++) begin
         if (k % 200 == 0) ch_en = NUM_CH'($urandom);
         if ($urandom_range(0, 5) == 0) pulse(NUM_CH'($urandom), 2'($urandom));
         else idle(1);
      end
      idle(20);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog run did not finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule